// File: doc/BRIEF.md
# Instruction Exception Entry Sequencer

This block sits beside the issue stage of a processor pipeline. It watches one decoded instruction per cycle and decides whether that instruction raises one of three exceptions. The first is a software trap requested by a trap instruction. The second is an illegal instruction found in the slot that follows a delayed branch. The third is an undefined opcode found anywhere else. The block keeps its own record of whether the instruction being presented sits in a delay slot. Delay-slot faults are therefore told apart from ordinary undefined code, and each gets its own vector.

When an exception is accepted, the block takes over a simple word-wide memory port. It saves the status word and then the return address on a downward-growing stack. Next it reads the handler address from a vector table at a base register plus four times the vector number. When that read returns, it redirects the fetch unit to the handler at once, with no delay slot. For the whole sequence it holds `busy`, which the pipeline uses to stall and to discard the instructions behind the faulting one.

Top module: `exc_entry_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `mem_req` and `redirect` are 0, `exc_class` is 0 (none), and `new_pc` and `new_sp` are 0.
- R2: A trap instruction that is not in a delay slot starts an entry with `exc_class` = 1 and vector number equal to the 8-bit `trap_imm`.
- R3: Undefined code (`ins_undef`) that is not in a delay slot starts an entry with `exc_class` = 3 and vector number `GEN_VEC` (default 4).
- R4: Undefined code, or any instruction that writes the PC (delayed branch, non-delayed conditional branch, trap), in a delay slot starts an entry with `exc_class` = 2 and vector number `SLOT_VEC` (default 6). This class wins over the trap class.
- R5: Only an accepted delayed branch (`ins_dbranch`) marks the next instruction as being in a delay slot. Cycles with `ins_valid` low do not clear the mark. The next valid instruction always clears it.
- R6: The first write of an entry stores `cur_sr` at `cur_sp`-4. The second write stores the return address at `cur_sp`-8. Both use the values sampled when the exception was detected.
- R7: The return address is the trap address + 2 for a trap, the faulting address for a general illegal instruction, and the address of the delayed branch for a slot fault.
- R8: After the two writes, the block issues one read (`mem_we`=0) at `vbr` + 4 × vector number.
- R9: Each request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is high. The next step begins only after that cycle.
- R10: In the cycle after the read is acknowledged, `redirect` is high for exactly one cycle, `new_pc` equals the read data, `new_sp` equals `cur_sp`-8, and `busy` is low.
- R11: `busy` is high from the cycle after detection until completion. Instructions presented while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | A decoded instruction is presented this cycle |
| ins_dbranch | input | 1 | The instruction is a delayed branch |
| ins_wr_pc | input | 1 | The instruction writes the PC |
| ins_trap | input | 1 | The instruction is a trap |
| ins_undef | input | 1 | The opcode is undefined |
| trap_imm | input | VW | Trap vector number |
| cur_pc | input | DW | Address of the presented instruction |
| cur_sr | input | DW | Current status word |
| cur_sp | input | DW | Current stack pointer |
| vbr | input | DW | Vector table base |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | DW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | Entry in progress: stall and flush |
| redirect | output | 1 | One-cycle pulse: fetch from `new_pc` |
| new_pc | output | DW | Handler address |
| new_sp | output | DW | Stack pointer after the pushes |
| exc_class | output | 2 | Class of the last exception (0 none, 1 trap, 2 slot, 3 general) |

## Verification
The assertions assume that the memory side raises `mem_ack` only while a request is pending and never more than once per request. They also assume that `cur_sp`, `cur_sr` and `vbr` matter only in the cycle an exception is detected. The bench's memory model answers only pending requests, with a latency it sets per scenario from zero upward, and it returns read data that depends on the address. The stimulus keeps the decode flags consistent with real instructions: a delayed branch also carries the PC-write flag. It also places instructions deliberately during `busy` to show they are ignored.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_TRAP = 2'd1,
    EXC_SLOT = 2'd2,
    EXC_GEN  = 2'd3
  } exc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_SR = 2'd1,
    ST_PUSH_PC = 2'd2,
    ST_VEC_RD  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic dbranch;
    logic wr_pc;
    logic trap;
    logic undef;
  } ins_flags_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int VW         = 8,
  parameter int SLOT_VEC   = 6,
  parameter int GEN_VEC    = 4,
  parameter int INSN_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins_valid,
  input  logic          accept,
  input  logic          take,
  input  ins_flags_t    flags,
  input  logic [DW-1:0] cur_pc,
  input  logic [VW-1:0] trap_imm,
  output exc_kind_e     kind,
  output logic [VW-1:0] vec_num,
  output logic [DW-1:0] save_pc
);
  localparam logic [VW-1:0] SLOT_V = VW'(SLOT_VEC);
  localparam logic [VW-1:0] GEN_V  = VW'(GEN_VEC);
  localparam logic [DW-1:0] STEP   = DW'(INSN_BYTES);

  logic          in_slot;
  logic [DW-1:0] branch_pc;
  logic          pc_writer;

  // A delayed branch or a trap writes the PC even if the decoder leaves
  // the separate PC-write flag low.
  assign pc_writer = flags.wr_pc | flags.dbranch | flags.trap;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_slot   <= 1'b0;
      branch_pc <= '0;
    end else if (take) begin
      in_slot <= 1'b0;
    end else if (ins_valid && accept) begin
      in_slot <= flags.dbranch;
      if (flags.dbranch) branch_pc <= cur_pc;
    end
  end

  always_comb begin
    kind    = EXC_NONE;
    vec_num = '0;
    save_pc = cur_pc;
    if (in_slot && (flags.undef || pc_writer)) begin
      kind    = EXC_SLOT;
      vec_num = SLOT_V;
      save_pc = branch_pc;
    end else if (flags.undef) begin
      kind    = EXC_GEN;
      vec_num = GEN_V;
    end else if (flags.trap) begin
      kind    = EXC_TRAP;
      vec_num = trap_imm;
      save_pc = cur_pc + STEP;
    end
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int VW         = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  exc_kind_e     kind,
  input  logic [VW-1:0] vec_num,
  input  logic [DW-1:0] save_pc,
  input  logic [DW-1:0] cur_sr,
  input  logic [DW-1:0] cur_sp,
  input  logic [DW-1:0] vbr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          redirect,
  output logic [DW-1:0] new_pc,
  output logic [DW-1:0] new_sp,
  output logic [1:0]    exc_class
);
  localparam logic [DW-1:0] WB  = DW'(WORD_BYTES);
  localparam logic [DW-1:0] WB2 = DW'(2 * WORD_BYTES);

  seq_state_e    state;
  logic [DW-1:0] sp_base;
  logic [DW-1:0] pc_hold;
  logic [DW-1:0] vec_addr;
  logic          acked;

  assign acked = mem_req && mem_ack;
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      redirect  <= 1'b0;
      new_pc    <= '0;
      new_sp    <= '0;
      exc_class <= EXC_NONE;
      sp_base   <= '0;
      pc_hold   <= '0;
      vec_addr  <= '0;
    end else begin
      redirect <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_PUSH_SR;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur_sp - WB;
            mem_wdata <= cur_sr;
            sp_base   <= cur_sp;
            pc_hold   <= save_pc;
            vec_addr  <= vbr + DW'(vec_num) * WB;
            exc_class <= kind;
          end
        end
        ST_PUSH_SR: begin
          if (acked) begin
            state     <= ST_PUSH_PC;
            mem_addr  <= sp_base - WB2;
            mem_wdata <= pc_hold;
          end
        end
        ST_PUSH_PC: begin
          if (acked) begin
            state     <= ST_VEC_RD;
            mem_we    <= 1'b0;
            mem_addr  <= vec_addr;
            mem_wdata <= '0;
          end
        end
        default: begin
          if (acked) begin
            state    <= ST_IDLE;
            mem_req  <= 1'b0;
            redirect <= 1'b1;
            new_pc   <= mem_rdata;
            new_sp   <= sp_base - WB2;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int VW         = 8,
  parameter int SLOT_VEC   = 6,
  parameter int GEN_VEC    = 4,
  parameter int INSN_BYTES = 2,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins_valid,
  input  logic          ins_dbranch,
  input  logic          ins_wr_pc,
  input  logic          ins_trap,
  input  logic          ins_undef,
  input  logic [VW-1:0] trap_imm,
  input  logic [DW-1:0] cur_pc,
  input  logic [DW-1:0] cur_sr,
  input  logic [DW-1:0] cur_sp,
  input  logic [DW-1:0] vbr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          redirect,
  output logic [DW-1:0] new_pc,
  output logic [DW-1:0] new_sp,
  output logic [1:0]    exc_class
);
  ins_flags_t    flags;
  exc_kind_e     kind;
  logic [VW-1:0] vec_num;
  logic [DW-1:0] save_pc;
  logic          start;

  assign flags = '{dbranch: ins_dbranch, wr_pc: ins_wr_pc, trap: ins_trap, undef: ins_undef};
  assign start = ins_valid && !busy && (kind != EXC_NONE);

  exc_classify #(
    .DW(DW), .VW(VW), .SLOT_VEC(SLOT_VEC), .GEN_VEC(GEN_VEC), .INSN_BYTES(INSN_BYTES)
  ) classify_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .accept(!busy), .take(start),
    .flags(flags), .cur_pc(cur_pc), .trap_imm(trap_imm),
    .kind(kind), .vec_num(vec_num), .save_pc(save_pc)
  );

  exc_seq #(
    .DW(DW), .VW(VW), .WORD_BYTES(WORD_BYTES)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .vec_num(vec_num),
    .save_pc(save_pc), .cur_sr(cur_sr), .cur_sp(cur_sp), .vbr(vbr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .redirect(redirect),
    .new_pc(new_pc), .new_sp(new_sp), .exc_class(exc_class)
  );
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ins_valid,
  input logic          ins_undef,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          redirect,
  input logic [DW-1:0] new_pc
);
  // R9: an unanswered request stays put
  a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11: memory traffic only during an entry
  a_r11_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R3 / R11: undefined code while idle begins with a write
  a_r3_undef_starts: assert property (@(posedge clk) disable iff (rst)
    ins_valid && !busy && ins_undef |=> busy && mem_req && mem_we);

  // R10: vector read answered -> redirect with its data
  a_r10_redirect_data: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we && mem_ack |=> redirect && !busy && new_pc == $past(mem_rdata));

  // R10: redirect is a single-cycle pulse
  a_r10_redirect_pulse: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_undef(ins_undef), .busy(busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .redirect(redirect), .new_pc(new_pc)
);

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 0, ins_dbranch = 0, ins_wr_pc = 0, ins_trap = 0, ins_undef = 0;
  logic [7:0]  trap_imm = 0;
  logic [31:0] cur_pc = 0, cur_sr = 32'h0000_00F0, cur_sp = 32'h0000_8000, vbr = 32'h0000_0400;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        busy, redirect;
  logic [31:0] new_pc, new_sp;
  logic [1:0]  exc_class;

  int errors = 0, checks = 0, cyc = 0, lat = 0, lat_cnt = 0;
  logic [31:0] wr_addr_q[$], wr_data_q[$], rd_addr_last;

  always #2.5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_dbranch(ins_dbranch),
    .ins_wr_pc(ins_wr_pc), .ins_trap(ins_trap), .ins_undef(ins_undef), .trap_imm(trap_imm),
    .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_sp(cur_sp), .vbr(vbr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .redirect(redirect), .new_pc(new_pc),
    .new_sp(new_sp), .exc_class(exc_class)
  );

  function automatic logic [31:0] vec_data(input logic [31:0] a);
    return 32'hA500_0000 ^ a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int          m_phase = 0, m_class = 0;
  bit          m_slot = 0;
  logic [31:0] m_brpc = 0, m_sp = 0, m_spc = 0, m_vaddr = 0;
  logic        e_req = 0, e_we = 0, e_redirect = 0;
  logic [31:0] e_addr = 0, e_wdata = 0, e_newpc = 0, e_newsp = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_phase = 0; m_class = 0; m_slot = 0; e_req = 0; e_we = 0; e_redirect = 0;
      e_newpc = 0; e_newsp = 0;
    end else begin
      e_redirect = 0;
      if (m_phase == 0) begin
        if (ins_valid) begin
          int k; int v;
          k = 0; v = 0;
          if (m_slot && (ins_undef || ins_wr_pc || ins_dbranch || ins_trap)) begin
            k = 2; v = 6; m_spc = m_brpc;
          end else if (ins_undef) begin
            k = 3; v = 4; m_spc = cur_pc;
          end else if (ins_trap) begin
            k = 1; v = int'(trap_imm); m_spc = cur_pc + 2;
          end
          if (k != 0) begin
            m_phase = 1; m_class = k; m_slot = 0; m_sp = cur_sp;
            m_vaddr = vbr + 32'(v * 4);
            e_req = 1; e_we = 1; e_addr = cur_sp - 4; e_wdata = cur_sr;
          end else begin
            m_slot = ins_dbranch;
            if (ins_dbranch) m_brpc = cur_pc;
          end
        end
      end else if (mem_ack) begin
        if (m_phase == 1) begin
          m_phase = 2; e_addr = m_sp - 8; e_wdata = m_spc;
        end else if (m_phase == 2) begin
          m_phase = 3; e_we = 0; e_addr = m_vaddr;
        end else begin
          m_phase = 0; e_req = 0; e_redirect = 1;
          e_newpc = mem_rdata; e_newsp = m_sp - 8;
        end
      end
    end
    #1;
    if (!rst) begin
      chk("R11 busy", 32'(busy), 32'(m_phase != 0));
      chk("R9 mem_req", 32'(mem_req), 32'(e_req));
      if (e_req) begin
        chk("R9 mem_we", 32'(mem_we), 32'(e_we));
        chk(e_we ? "R6 mem_addr" : "R8 mem_addr", mem_addr, e_addr);
        if (e_we) chk("R7 mem_wdata", mem_wdata, e_wdata);
      end
      chk("R10 redirect", 32'(redirect), 32'(e_redirect));
      chk("R10 new_pc", new_pc, e_newpc);
      chk("R10 new_sp", new_sp, e_newsp);
      chk("R4 exc_class", 32'(exc_class), 32'(m_class));
    end
  end

  // ---------------- memory responder ----------------
  always @(negedge clk) begin
    mem_ack = 0;
    if (!rst && mem_req) begin
      if (lat_cnt >= lat) begin
        mem_ack = 1; lat_cnt = 0;
        mem_rdata = vec_data(mem_addr);
        if (mem_we) begin wr_addr_q.push_back(mem_addr); wr_data_q.push_back(mem_wdata); end
        else rd_addr_last = mem_addr;
      end else lat_cnt++;
    end else lat_cnt = 0;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) if (cyc > 20000) begin
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic issue(input bit dbr, input bit wrpc, input bit trp, input bit und,
                       input logic [31:0] pc, input logic [7:0] imm);
    @(negedge clk);
    ins_valid = 1; ins_dbranch = dbr; ins_wr_pc = wrpc; ins_trap = trp; ins_undef = und;
    cur_pc = pc; trap_imm = imm;
    @(negedge clk);
    ins_valid = 0; ins_dbranch = 0; ins_wr_pc = 0; ins_trap = 0; ins_undef = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1;
      if (redirect) break;
    end
    @(negedge clk);
  endtask

  task automatic check_entry(input string tag, input int kls, input logic [31:0] spc,
                             input logic [31:0] vaddr);
    chk({tag, " write count R6"}, 32'(wr_addr_q.size()), 32'd2);
    if (wr_addr_q.size() == 2) begin
      chk({tag, " SR addr R6"}, wr_addr_q[0], cur_sp - 4);
      chk({tag, " SR data R6"}, wr_data_q[0], cur_sr);
      chk({tag, " PC addr R6"}, wr_addr_q[1], cur_sp - 8);
      chk({tag, " PC data R7"}, wr_data_q[1], spc);
    end
    chk({tag, " vector addr R8"}, rd_addr_last, vaddr);
    chk({tag, " new_pc R10"}, new_pc, vec_data(vaddr));
    chk({tag, " new_sp R10"}, new_sp, cur_sp - 8);
    chk({tag, " class"}, 32'(exc_class), 32'(kls));
    wr_addr_q.delete(); wr_data_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 redirect", 32'(redirect), 0);
    chk("R1 exc_class", 32'(exc_class), 0);
    chk("R1 new_pc", new_pc, 0);

    // plain instruction: nothing happens
    issue(0, 0, 0, 0, 32'h100, 0);
    repeat (2) @(negedge clk);
    chk("R11 idle after plain insn", 32'(busy), 0);

    // R2 trap, zero latency
    lat = 0;
    issue(0, 1, 1, 0, 32'h1000, 8'h21);
    wait_done();
    check_entry("R2 trap", 1, 32'h1002, 32'h484);

    // R3 general illegal, latency 2
    lat = 2; cur_sp = 32'h0000_9000; cur_sr = 32'h0000_0301;
    issue(0, 0, 0, 1, 32'h2000, 0);
    wait_done();
    check_entry("R3 general", 3, 32'h2000, 32'h410);

    // R4/R5 undef in slot after bubbles
    issue(1, 1, 0, 0, 32'h3000, 0);
    repeat (2) @(negedge clk);
    issue(0, 0, 0, 1, 32'h3002, 0);
    wait_done();
    check_entry("R4 slot undef", 2, 32'h3000, 32'h418);

    // R4 PC-writing conditional branch in slot, latency 1
    lat = 1;
    issue(1, 1, 0, 0, 32'h4000, 0);
    issue(0, 1, 0, 0, 32'h4002, 0);
    wait_done();
    check_entry("R4 slot branch", 2, 32'h4000, 32'h418);

    // R4 trap in slot takes the slot class
    issue(1, 1, 0, 0, 32'h4800, 0);
    issue(0, 1, 1, 0, 32'h4802, 8'h33);
    wait_done();
    check_entry("R4 slot trap", 2, 32'h4800, 32'h418);

    // R5 slot mark lasts one instruction
    lat = 0;
    issue(1, 1, 0, 0, 32'h7000, 0);
    issue(0, 0, 0, 0, 32'h7002, 0);
    issue(0, 0, 0, 1, 32'h7004, 0);
    wait_done();
    check_entry("R5 slot expired", 3, 32'h7004, 32'h410);

    // R11 instructions during busy are ignored
    lat = 3;
    issue(0, 0, 0, 1, 32'h5000, 0);
    issue(0, 1, 1, 0, 32'h6000, 8'h7);
    wait_done();
    repeat (4) @(negedge clk);
    chk("R11 busy low after", 32'(busy), 0);
    check_entry("R11 ignored while busy", 3, 32'h5000, 32'h410);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule